// File: doc/BRIEF.md
# Two-Write Two-Read Memory with Last-Writer Table

This block is a small random-access memory that accepts two writes and serves two reads in every clock cycle. Each write port and each read port has its own address. The block is built only from simple storage arrays, and each array has one write side and one read side. Every write port owns one array per read port, so the block holds four copies. A write goes into both arrays of its own port.

A one-bit-per-address table, held in flip-flops, records which write port last stored a word at each address. A read fetches the word from the two arrays that serve it and looks up the table at the same time. The registered table bit then chooses which array's output reaches the read port. Reads are synchronous and return data one cycle after the address is presented. When both write ports target the same address in the same cycle, write port 1 wins. A reader uses the block like an ordinary dual-read, dual-write register file.

Top module: `lvt_dual_write_ram`

## Requirements
- R1: Writes from both write ports to different addresses in the same cycle are both stored, and either read port can later read each word.
- R2: A read returns the word from the most recent write to that address, whichever write port made it and however the ports took turns on that address.
- R3: When both write ports are enabled at the same address in one cycle, the word from write port 1 is stored and the word from write port 0 is discarded.
- R4: Read data appears on the read port in the cycle after the clock edge that samples the read address. Before that edge the previous result is still shown.
- R5: A read of an address that is written on the same clock edge returns the value from before the write, on both read ports.
- R6: Reset returns every table entry to write port 0. After reset, an address that write port 1 last wrote reads back the last word that write port 0 stored there. The array contents are not reset.
- R7: While a read address is held and no write occurs, the read data stays constant.
- R8: The two read ports work independently and can read different addresses in the same cycle.
- R9: A write port whose enable is low changes nothing, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the last-writer table |
| wr0_en | input | 1 | Write enable, write port 0 |
| wr0_addr | input | AW | Write address, write port 0 |
| wr0_data | input | DW | Write data, write port 0 |
| wr1_en | input | 1 | Write enable, write port 1 (wins on an address collision) |
| wr1_addr | input | AW | Write address, write port 1 |
| wr1_data | input | DW | Write data, write port 1 |
| rd0_addr | input | AW | Read address, read port 0 |
| rd0_data | output | DW | Read data, read port 0, one cycle of latency |
| rd1_addr | input | AW | Read address, read port 1 |
| rd1_data | output | DW | Read data, read port 1, one cycle of latency |

## Verification
The bench aims at same-address write collisions. If the table and the arrays disagree on which port won, a read returns write port 0's word or a stale word. It alternates the two write ports on a single address. A table that did not track the last writer would keep steering the read to the array that first held the word. It reads an address on the same edge that writes it, which exposes a table that is looked up after its update, because that read returns a mix of old and new data. It also resets after port 1 has written and then expects port 0's older word, which shows whether the table really returns to port 0 while the arrays keep their contents.

// File: rtl/lvt_dual_write_ram.sv
module lvt_dual_write_ram #(
  parameter int DW = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr0_en,
  input  logic [AW-1:0] wr0_addr,
  input  logic [DW-1:0] wr0_data,
  input  logic          wr1_en,
  input  logic [AW-1:0] wr1_addr,
  input  logic [DW-1:0] wr1_data,
  input  logic [AW-1:0] rd0_addr,
  output logic [DW-1:0] rd0_data,
  input  logic [AW-1:0] rd1_addr,
  output logic [DW-1:0] rd1_data
);

  logic [AW-1:0]    wa [2];
  logic [AW-1:0]    ra [2];
  logic [DW-1:0]    wd [2];
  logic [1:0]       we;
  logic             clash;
  logic [DEPTH-1:0] lvt;
  logic [1:0]       sel_q;
  logic [DW-1:0]    bank_q [4];

  assign wa[0] = wr0_addr;
  assign wa[1] = wr1_addr;
  assign wd[0] = wr0_data;
  assign wd[1] = wr1_data;
  assign ra[0] = rd0_addr;
  assign ra[1] = rd1_addr;

  assign clash = wr0_en && wr1_en && (wr0_addr == wr1_addr);
  assign we[0] = wr0_en && !clash;
  assign we[1] = wr1_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvt   <= '0;
      sel_q <= '0;
    end else begin
      sel_q[0] <= lvt[rd0_addr];
      sel_q[1] <= lvt[rd1_addr];
      if (we[0]) lvt[wr0_addr] <= 1'b0;
      if (we[1]) lvt[wr1_addr] <= 1'b1;
    end
  end

  for (genvar gw = 0; gw < 2; gw++) begin : g_wport
    for (genvar gr = 0; gr < 2; gr++) begin : g_rport
      logic [DW-1:0] store [DEPTH];
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (we[gw]) store[wa[gw]] <= wd[gw];
        q <= store[ra[gr]];
      end
      assign bank_q[gw*2+gr] = q;
    end
  end

  assign rd0_data = sel_q[0] ? bank_q[2] : bank_q[0];
  assign rd1_data = sel_q[1] ? bank_q[3] : bank_q[1];

  AST_PORT1_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |=> lvt[$past(wr1_addr)]); // R3

  AST_PORT0_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && !(wr1_en && wr1_addr == wr0_addr)) |=> !lvt[$past(wr0_addr)]); // R2

  AST_TABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr0_en && !wr1_en) |=> $stable(lvt)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $rose(rst_n) |-> (lvt == '0)); // R6

  AST_READ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd0_addr) && !$past(wr0_en) && !$past(wr1_en) && $past(rst_n))
      |=> $stable(rd0_data)); // R7

endmodule

// File: tb/tb_lvt_dual_write_ram.sv
module tb_lvt_dual_write_ram;
  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic wr0_en = 0, wr1_en = 0;
  logic [AW-1:0] wr0_addr = '0, wr1_addr = '0, rd0_addr = '0, rd1_addr = '0;
  logic [DW-1:0] wr0_data = '0, wr1_data = '0;
  logic [DW-1:0] rd0_data, rd1_data;

  lvt_dual_write_ram #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

  always #10 clk = ~clk;

  int nvec = 0, nbad = 0;
  logic [DW-1:0] val [DEPTH];
  bit            ok  [DEPTH];
  logic [DW-1:0] b0  [DEPTH];
  bit            b0ok[DEPTH];

  task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit e0, input int a0, input logic [DW-1:0] d0,
                     input bit e1, input int a1, input logic [DW-1:0] d1,
                     input int r0, input int r1, input string tag);
    logic [DW-1:0] x0, x1;
    bit v0, v1;
    wr0_en = e0; wr0_addr = AW'(a0); wr0_data = d0;
    wr1_en = e1; wr1_addr = AW'(a1); wr1_data = d1;
    rd0_addr = AW'(r0); rd1_addr = AW'(r1);
    x0 = val[r0]; v0 = ok[r0];
    x1 = val[r1]; v1 = ok[r1];
    if (e0 && !(e1 && a0 == a1)) begin
      val[a0] = d0; ok[a0] = 1; b0[a0] = d0; b0ok[a0] = 1;
    end
    if (e1) begin val[a1] = d1; ok[a1] = 1; end
    @(negedge clk);
    if (v0) check(rd0_data, x0, {tag, " rd0"});
    if (v1) check(rd1_data, x1, {tag, " rd1"});
  endtask

  task automatic rd(input int r0, input int r1, input string tag);
    cyc(0, 0, '0, 0, 0, '0, r0, r1, tag);
  endtask

  task automatic t_parallel_writes;
    cyc(1, 8'h12, 16'hA012, 1, 8'h15, 16'hB015, 0, 0, "R1");
    rd(8'h12, 8'h15, "R1 R8");
    rd(8'h15, 8'h12, "R1 R8");
  endtask

  task automatic t_alternate;
    cyc(1, 3, 16'h0003, 0, 0, '0, 3, 3, "R2");
    cyc(0, 0, '0, 1, 3, 16'h1003, 3, 3, "R2");
    rd(3, 3, "R2");
    cyc(1, 3, 16'h2003, 0, 0, '0, 3, 3, "R2");
    rd(3, 3, "R2");
    check(rd0_data, 16'h2003, "R2 direct");
  endtask

  task automatic t_collision;
    cyc(1, 9, 16'hDEAD, 1, 9, 16'hBEEF, 0, 0, "R3");
    rd(9, 9, "R3");
    check(rd1_data, 16'hBEEF, "R3 direct");
  endtask

  task automatic t_latency;
    cyc(1, 20, 16'h2020, 1, 21, 16'h2121, 0, 0, "R4 setup");
    rd(20, 20, "R4");
    wr0_en = 0; wr1_en = 0; rd0_addr = 21;
    #5 check(rd0_data, 16'h2020, "R4 before edge");
    @(negedge clk);
    check(rd0_data, 16'h2121, "R4 after edge");
  endtask

  task automatic t_rbw;
    cyc(1, 30, 16'h0030, 1, 31, 16'h0031, 0, 0, "R5 setup");
    cyc(1, 30, 16'h1130, 1, 31, 16'h1131, 30, 31, "R5");
    rd(30, 31, "R5 after");
  endtask

  task automatic t_hold;
    rd(31, 30, "R7");
    rd(31, 30, "R7");
    rd(31, 30, "R7");
  endtask

  task automatic t_disabled;
    cyc(0, 30, 16'hFFFF, 0, 31, 16'hEEEE, 30, 31, "R9");
    rd(30, 31, "R9");
  endtask

  task automatic t_reset;
    cyc(1, 40, 16'h4000, 0, 0, '0, 0, 0, "R6 setup");
    cyc(0, 0, '0, 1, 40, 16'h4111, 0, 0, "R6 setup");
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < DEPTH; a++) begin val[a] = b0[a]; ok[a] = b0ok[a]; end
    rd(40, 40, "R6");
    check(rd0_data, 16'h4000, "R6 direct");
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++) begin
      int a0, a1;
      a0 = $urandom_range(0, 15);
      a1 = (i % 8 == 0) ? a0 : $urandom_range(0, 15);
      cyc($urandom_range(0, 1), a0, DW'($urandom), $urandom_range(0, 1), a1,
          DW'($urandom), $urandom_range(0, 15), $urandom_range(0, 15), "R2 R3 random");
    end
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin ok[a] = 0; b0ok[a] = 0; val[a] = '0; b0[a] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_parallel_writes();
    t_alternate();
    t_collision();
    t_latency();
    t_rbw();
    t_hold();
    t_disabled();
    t_reset();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule